// File: doc/BRIEF.md
# Register File Front End with Pointer Window and Stack Sequencer

This block sits in front of a 256-entry byte register file. A host port reads and writes registers by a logical address; any logical address whose upper nibble is 0xE lands in a sixteen-register window whose base comes from the upper nibble of a pointer register. Every other address reaches the register file unchanged. The translated address is presented on a port so that neighbouring logic can see the physical target.

A stack sequencer runs push and pop commands of one or two bytes. A mode bit in a control register picks where the stack lives. With the bit set, an 8-bit pointer (the low stack-pointer byte) addresses the register file itself. With the bit clear, the two stack-pointer bytes form a 16-bit pointer into an external byte-wide data memory. Each byte of a command takes one clock cycle. Pushes move the pointer down before they write. Pops read first and then move the pointer up. Two-byte values are stored high byte first, at the lower address.

Top module: `regfile_stack_front`

## Requirements
- R1: A logical address whose bits [7:4] equal 0xE is translated to {pointer[7:4], address[3:0]}, where pointer is the register at 0xFD. Every other logical address is passed to phys_addr unchanged.
- R2: After reset the pointer register at 0xFD reads 0x00 and the mode register at 0xF8 reads 0x04, so bit 2 is set and the internal stack is selected. stk_ready is 1, and pop_valid and dm_req are 0.
- R3: A host write with acc_we=1 stores acc_wdata at the translated address at the clock edge. acc_rdata shows, combinationally, the contents at the translated address. The stack-pointer bytes sit at 0xFE (high) and 0xFF (low).
- R4: When 0xF8 bit 2 is 1, a byte push (stk_pop=0, stk_word=0) lowers the byte at 0xFF by 1 and writes stk_wdata[7:0] into the register file at the new value. The byte at 0xFE does not change.
- R5: An internal word push (stk_word=1) lowers 0xFF by 2. It writes stk_wdata[15:8] at the new pointer and stk_wdata[7:0] at the new pointer plus 1.
- R6: A pop reads at the current pointer and then raises the pointer by 1 for a byte or by 2 for a word. pop_data returns a word as {byte at p, byte at p+1}, and returns a byte as {8'h00, byte at p}.
- R7: When 0xF8 bit 2 is 0, the pointer is the 16-bit value {0xFE, 0xFF}. It steps with a carry or borrow across both bytes, and the stack bytes go to data memory at that pointer through dm_req, dm_we, dm_addr and dm_wdata, or come back on dm_rdata in the same cycle.
- R8: An external word access uses two consecutive dm_req cycles. The first is at the lower address and carries the high byte; the second is at the lower address plus 1.
- R9: A command is accepted on a clock edge where stk_valid and stk_ready are both 1. stk_ready then stays low for 1 cycle for a byte or 2 cycles for a word. After a pop, pop_valid is high for exactly the one cycle in which stk_ready returns.
- R10: While the internal stack is selected, no stack command raises dm_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_addr | input | 8 | Host logical register address |
| acc_we | input | 1 | Host write enable |
| acc_wdata | input | 8 | Host write data |
| acc_rdata | output | 8 | Contents at the translated address |
| phys_addr | output | 8 | Translated register address |
| stk_valid | input | 1 | Stack command request |
| stk_pop | input | 1 | 1 = pop, 0 = push |
| stk_word | input | 1 | 1 = two bytes, 0 = one byte |
| stk_wdata | input | 16 | Push data; a byte push uses bits [7:0] |
| stk_ready | output | 1 | Sequencer idle, command can be accepted |
| pop_valid | output | 1 | One-cycle strobe for popped data |
| pop_data | output | 16 | Popped value |
| dm_req | output | 1 | Data memory access this cycle |
| dm_we | output | 1 | Data memory write |
| dm_addr | output | 16 | Data memory byte address |
| dm_wdata | output | 8 | Data memory write data |
| dm_rdata | input | 8 | Data memory read data, same cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit register width, a 16-bit external pointer, the window on nibble 0xE, and the control registers at 0xF8, 0xFD, 0xFE and 0xFF. These defaults mean a host write to the pointer register changes the window translation, and the pointer's lower nibble can be given a non-zero value to show that it is ignored. They also allow the external pointer to be steered through 0x0000 and 0x0100, which exercises the borrow and carry between the two pointer bytes and a word that straddles the top of the 16-bit space.

// File: rtl/rfs_pkg.sv
// Package: shared constants and types for the register file front end.
// Assumes register width equals register address width (8 bits by default).
package rfs_pkg;
    localparam int            REG_W       = 8;
    localparam logic [3:0]    WINDOW_NIB  = 4'hE;
    localparam logic [7:0]    PTR_ADDR    = 8'hFD;
    localparam logic [7:0]    SPHI_ADDR   = 8'hFE;
    localparam logic [7:0]    SPLO_ADDR   = 8'hFF;
    localparam logic [7:0]    MODE_ADDR   = 8'hF8;
    localparam int            MODE_BIT    = 2;
    localparam logic [7:0]    MODE_RESET  = 8'h04;

    // Sequencer phase: idle, first byte, second byte.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FIRST  = 2'd1,
        SQ_SECOND = 2'd2
    } seq_phase_t;

    // Latched attributes of the command in flight.
    typedef struct packed {
        logic pop;
        logic word;
        logic internal;
    } stk_op_t;
endpackage

// File: rtl/rfs_rp_xlate.sv
// Module: rfs_rp_xlate
// Translates a logical register address into a physical one. Addresses whose
// top nibble equals WIN are redirected into the 16-register window selected by
// the top nibble of the pointer register. Assumes W >= 8.
module rfs_rp_xlate #(
    parameter int         W   = 8,
    parameter logic [3:0] WIN = 4'hE
) (
    input  logic [W-1:0] log_addr,
    input  logic [W-1:0] ptr,
    output logic [W-1:0] phys_addr
);
    // Window redirect or straight pass.
    always_comb begin
        if (log_addr[W-1 -: 4] == WIN)
            phys_addr = {ptr[W-1 -: 4], log_addr[W-5:0]};
        else
            phys_addr = log_addr;
    end
endmodule

// File: rtl/rfs_rf_core.sv
// Module: rfs_rf_core
// Register storage: a plain byte array plus dedicated flops for the window
// pointer, the mode register and both stack-pointer bytes. There are two write
// ports (host, stack) and two combinational read ports. The write order in one
// cycle is host, then pointer load, then stack data; the later one wins.
module rfs_rf_core #(
    parameter int         W        = 8,
    parameter logic [7:0] PTR_A    = 8'hFD,
    parameter logic [7:0] SPH_A    = 8'hFE,
    parameter logic [7:0] SPL_A    = 8'hFF,
    parameter logic [7:0] MODE_A   = 8'hF8,
    parameter int         MODE_B   = 2,
    parameter logic [7:0] MODE_RST = 8'h04
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_we,
    input  logic [W-1:0]   h_addr,
    input  logic [W-1:0]   h_wdata,
    output logic [W-1:0]   h_rdata,
    input  logic           s_we,
    input  logic [W-1:0]   s_addr,
    input  logic [W-1:0]   s_wdata,
    output logic [W-1:0]   s_rdata,
    input  logic           sp_ld,
    input  logic [2*W-1:0] sp_nxt,
    output logic [W-1:0]   ptr,
    output logic [2*W-1:0] sp,
    output logic           mode_int
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] ptr_q, mode_q, sph_q, spl_q;

    // General storage writes; the stack port is applied after the host port.
    always_ff @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wdata;
        if (s_we) mem[s_addr] <= s_wdata;
    end

    // Dedicated registers with reset and a fixed write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mode_q <= W'(MODE_RST);
            sph_q  <= '0;
            spl_q  <= '0;
        end else begin
            if (h_we) begin
                if (h_addr == W'(PTR_A))  ptr_q  <= h_wdata;
                if (h_addr == W'(MODE_A)) mode_q <= h_wdata;
                if (h_addr == W'(SPH_A))  sph_q  <= h_wdata;
                if (h_addr == W'(SPL_A))  spl_q  <= h_wdata;
            end
            if (sp_ld) {sph_q, spl_q} <= sp_nxt;
            if (s_we) begin
                if (s_addr == W'(PTR_A))  ptr_q  <= s_wdata;
                if (s_addr == W'(MODE_A)) mode_q <= s_wdata;
                if (s_addr == W'(SPH_A))  sph_q  <= s_wdata;
                if (s_addr == W'(SPL_A))  spl_q  <= s_wdata;
            end
        end
    end

    // Host read mux: dedicated registers override the array.
    always_comb begin
        if      (h_addr == W'(PTR_A))  h_rdata = ptr_q;
        else if (h_addr == W'(MODE_A)) h_rdata = mode_q;
        else if (h_addr == W'(SPH_A))  h_rdata = sph_q;
        else if (h_addr == W'(SPL_A))  h_rdata = spl_q;
        else                           h_rdata = mem[h_addr];
    end

    // Stack read mux, same decode as the host side.
    always_comb begin
        if      (s_addr == W'(PTR_A))  s_rdata = ptr_q;
        else if (s_addr == W'(MODE_A)) s_rdata = mode_q;
        else if (s_addr == W'(SPH_A))  s_rdata = sph_q;
        else if (s_addr == W'(SPL_A))  s_rdata = spl_q;
        else                           s_rdata = mem[s_addr];
    end

    assign ptr      = ptr_q;
    assign sp       = {sph_q, spl_q};
    assign mode_int = mode_q[MODE_B];

    // R2: the window pointer is zero on the first edge after reset.
    p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ptr == '0));
endmodule

// File: rtl/rfs_stk_seq.sv
// Module: rfs_stk_seq
// Stack sequencer. It accepts a push or pop and updates the stack pointer in
// the accept cycle, then moves one byte per cycle, high byte first. The bytes
// go to the register file (internal mode) or to data memory (external mode).
// Assumes a data memory that returns read data in the same cycle.
module rfs_stk_seq
    import rfs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_pop,
    input  logic           cmd_word,
    input  logic [2*W-1:0] cmd_wdata,
    output logic           cmd_ready,
    output logic           pop_valid,
    output logic [2*W-1:0] pop_data,
    input  logic           mode_int,
    input  logic [2*W-1:0] sp,
    output logic           sp_ld,
    output logic [2*W-1:0] sp_nxt,
    output logic           rf_we,
    output logic [W-1:0]   rf_addr,
    output logic [W-1:0]   rf_wdata,
    input  logic [W-1:0]   rf_rdata,
    output logic           dm_req,
    output logic           dm_we,
    output logic [2*W-1:0] dm_addr,
    output logic [W-1:0]   dm_wdata,
    input  logic [W-1:0]   dm_rdata
);
    localparam int SPW = 2 * W;

    seq_phase_t     phase;
    stk_op_t        op;
    logic [SPW-1:0] base, wbuf, acc, cur, ext_nxt;
    logic [W-1:0]   int_low, byte_out, byte_in;
    logic [SPW-1:0] step;
    logic           accept, xfer;

    assign cmd_ready = (phase == SQ_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign xfer      = (phase != SQ_IDLE);

    // Next pointer: an 8-bit wrap for internal mode, a full 16-bit step for external.
    always_comb begin
        step    = cmd_word ? SPW'(2) : SPW'(1);
        ext_nxt = cmd_pop ? sp + step : sp - step;
        int_low = cmd_pop ? sp[W-1:0] + step[W-1:0] : sp[W-1:0] - step[W-1:0];
        sp_nxt  = mode_int ? {sp[SPW-1:W], int_low} : ext_nxt;
        sp_ld   = accept;
    end

    // Byte address and data for the current transfer cycle.
    always_comb begin
        cur      = base + ((phase == SQ_SECOND) ? SPW'(1) : SPW'(0));
        byte_out = (phase == SQ_FIRST && op.word) ? wbuf[SPW-1:W] : wbuf[W-1:0];
        byte_in  = op.internal ? rf_rdata : dm_rdata;
        rf_we    = xfer && op.internal && !op.pop;
        rf_addr  = cur[W-1:0];
        rf_wdata = byte_out;
        dm_req   = xfer && !op.internal;
        dm_we    = dm_req && !op.pop;
        dm_addr  = cur;
        dm_wdata = byte_out;
    end

    // Phase sequencing, command latch and pop assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= SQ_IDLE;
            op        <= '0;
            base      <= '0;
            wbuf      <= '0;
            acc       <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= 1'b0;
            case (phase)
                SQ_IDLE: if (accept) begin
                    op    <= '{pop: cmd_pop, word: cmd_word, internal: mode_int};
                    base  <= cmd_pop ? sp : sp_nxt;
                    wbuf  <= cmd_wdata;
                    acc   <= '0;
                    phase <= SQ_FIRST;
                end
                SQ_FIRST: begin
                    if (op.pop) acc <= {acc[W-1:0], byte_in};
                    if (op.word) phase <= SQ_SECOND;
                    else begin
                        phase     <= SQ_IDLE;
                        pop_valid <= op.pop;
                    end
                end
                default: begin
                    if (op.pop) acc <= {acc[W-1:0], byte_in};
                    phase     <= SQ_IDLE;
                    pop_valid <= op.pop;
                end
            endcase
        end
    end

    assign pop_data = acc;

    // R9: the sequencer is busy right after it accepts a command.
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready);

    // R9: the pop strobe lasts a single cycle.
    p_pop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);

    // R4: an internal byte push lowers the low pointer byte by one and leaves the high byte.
    p_int_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_int && !cmd_pop && !cmd_word) |=>
        ((sp[W-1:0] == W'($past(sp[W-1:0]) - 1'b1)) && (sp[SPW-1:W] == $past(sp[SPW-1:W]))));

    // R8: an external word continues with a memory cycle at the next address.
    p_ext_word_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == SQ_FIRST && !op.internal && op.word) |=>
        (dm_req && (dm_addr == SPW'($past(dm_addr) + 1'b1))));

    // R10: a command accepted in internal mode makes no memory request.
    p_int_no_dm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_int) |=> !dm_req);
endmodule

// File: rtl/regfile_stack_front.sv
// Module: regfile_stack_front (top)
// Register file front end: window translation for host accesses and a stack
// sequencer that targets either the register file or external data memory.
// Assumes a same-cycle data memory and a register width of 8 bits or more.
module regfile_stack_front
    import rfs_pkg::*;
#(
    parameter int         W        = REG_W,
    parameter logic [3:0] WIN      = WINDOW_NIB,
    parameter logic [7:0] PTR_A    = PTR_ADDR,
    parameter logic [7:0] SPH_A    = SPHI_ADDR,
    parameter logic [7:0] SPL_A    = SPLO_ADDR,
    parameter logic [7:0] MODE_A   = MODE_ADDR,
    parameter int         MODE_B   = MODE_BIT,
    parameter logic [7:0] MODE_RST = MODE_RESET
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   acc_addr,
    input  logic           acc_we,
    input  logic [W-1:0]   acc_wdata,
    output logic [W-1:0]   acc_rdata,
    output logic [W-1:0]   phys_addr,
    input  logic           stk_valid,
    input  logic           stk_pop,
    input  logic           stk_word,
    input  logic [2*W-1:0] stk_wdata,
    output logic           stk_ready,
    output logic           pop_valid,
    output logic [2*W-1:0] pop_data,
    output logic           dm_req,
    output logic           dm_we,
    output logic [2*W-1:0] dm_addr,
    output logic [W-1:0]   dm_wdata,
    input  logic [W-1:0]   dm_rdata
);
    logic [W-1:0]   ptr, s_addr, s_wdata, s_rdata;
    logic [2*W-1:0] sp, sp_nxt;
    logic           mode_int, sp_ld, s_we;

    rfs_rp_xlate #(.W(W), .WIN(WIN)) u_xlate (
        .log_addr  (acc_addr),
        .ptr       (ptr),
        .phys_addr (phys_addr)
    );

    rfs_rf_core #(
        .W(W), .PTR_A(PTR_A), .SPH_A(SPH_A), .SPL_A(SPL_A),
        .MODE_A(MODE_A), .MODE_B(MODE_B), .MODE_RST(MODE_RST)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_we     (acc_we),
        .h_addr   (phys_addr),
        .h_wdata  (acc_wdata),
        .h_rdata  (acc_rdata),
        .s_we     (s_we),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_rdata  (s_rdata),
        .sp_ld    (sp_ld),
        .sp_nxt   (sp_nxt),
        .ptr      (ptr),
        .sp       (sp),
        .mode_int (mode_int)
    );

    rfs_stk_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (stk_valid),
        .cmd_pop   (stk_pop),
        .cmd_word  (stk_word),
        .cmd_wdata (stk_wdata),
        .cmd_ready (stk_ready),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .mode_int  (mode_int),
        .sp        (sp),
        .sp_ld     (sp_ld),
        .sp_nxt    (sp_nxt),
        .rf_we     (s_we),
        .rf_addr   (s_addr),
        .rf_wdata  (s_wdata),
        .rf_rdata  (s_rdata),
        .dm_req    (dm_req),
        .dm_we     (dm_we),
        .dm_addr   (dm_addr),
        .dm_wdata  (dm_wdata),
        .dm_rdata  (dm_rdata)
    );

    // R1: addresses outside the window reach the register file unchanged.
    p_direct_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[W-1 -: 4] != WIN) |-> (phys_addr == acc_addr));
endmodule

// File: tb/test_regfile_stack_front.sv
// Scoreboard bench: stack tasks queue expected pop values and a monitor
// compares them against pop_data when pop_valid appears.
module test_regfile_stack_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  acc_addr, acc_wdata, acc_rdata, phys_addr;
    logic        acc_we;
    logic        stk_valid, stk_pop, stk_word, stk_ready, pop_valid;
    logic [15:0] stk_wdata, pop_data, dm_addr;
    logic        dm_req, dm_we;
    logic [7:0]  dm_wdata, dm_rdata;

    int errs   = 0;
    int checks = 0;
    logic [15:0] exp_q  [$];
    logic [15:0] dm_log [$];
    logic [7:0]  dm_mem [0:65535];

    always #5 clk = ~clk;

    regfile_stack_front i_regfile_stack_front (
        .clk(clk), .rst_n(rst_n),
        .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .phys_addr(phys_addr),
        .stk_valid(stk_valid), .stk_pop(stk_pop), .stk_word(stk_word),
        .stk_wdata(stk_wdata), .stk_ready(stk_ready),
        .pop_valid(pop_valid), .pop_data(pop_data),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata)
    );

    assign dm_rdata = dm_mem[dm_addr];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Data memory model and request log, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && dm_req) begin
            dm_log.push_back(dm_addr);
            if (dm_we) dm_mem[dm_addr] = dm_wdata;
        end
    end

    // Scoreboard monitor for popped values (R6).
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (exp_q.size() == 0) chk("R6 unexpected pop", 32'(pop_data), 32'hFFFF_FFFF);
            else                   chk("R6 pop data", 32'(pop_data), 32'(exp_q.pop_front()));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_we = 1'b1;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        acc_addr = a;
        #1;
        chk(tag, 32'(acc_rdata), 32'(exp));
    endtask

    task automatic map_chk(input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        acc_addr = a;
        #1;
        chk("R1 translation", 32'(phys_addr), 32'(exp));
    endtask

    // Driver: issue one stack command, queue the expected pop, and check busy length (R9).
    task automatic stk(input logic pop, input logic word, input logic [15:0] d,
                       input logic [15:0] exp_pop);
        int busy;
        @(negedge clk);
        stk_valid = 1'b1; stk_pop = pop; stk_word = word; stk_wdata = d;
        if (pop) exp_q.push_back(exp_pop);
        @(posedge clk);
        #1;
        stk_valid = 1'b0;
        busy = 0;
        @(negedge clk);
        while (!stk_ready) begin
            busy++;
            @(negedge clk);
        end
        chk("R9 busy cycles", 32'(busy), word ? 32'd2 : 32'd1);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errs++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 65536; i++) dm_mem[i] = 8'h00;
        rst_n = 1'b0; acc_addr = '0; acc_we = 1'b0; acc_wdata = '0;
        stk_valid = 1'b0; stk_pop = 1'b0; stk_word = 1'b0; stk_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2 ready after reset", 32'(stk_ready), 32'd1);
        chk("R2 pop_valid after reset", 32'(pop_valid), 32'd0);
        chk("R2 dm_req after reset", 32'(dm_req), 32'd0);
        rd_chk("R2 pointer reset", 8'hFD, 8'h00);
        rd_chk("R2 mode reset", 8'hF8, 8'h04);

        // R1 window translation
        map_chk(8'h35, 8'h35);
        wr(8'hFD, 8'h7A);
        map_chk(8'hE3, 8'h73);
        map_chk(8'hEF, 8'h7F);
        map_chk(8'hFD, 8'hFD);

        // R3 host access through the window and directly
        wr(8'hE3, 8'h5C);
        rd_chk("R3 aliased write", 8'h73, 8'h5C);
        wr(8'hFE, 8'h12);
        wr(8'hFF, 8'h40);
        rd_chk("R3 stack high byte", 8'hFE, 8'h12);

        // R4 internal byte push
        dm_log.delete();
        stk(1'b0, 1'b0, 16'h00A5, 16'h0000);
        rd_chk("R4 pointer low", 8'hFF, 8'h3F);
        rd_chk("R4 stored byte", 8'h3F, 8'hA5);
        rd_chk("R4 pointer high kept", 8'hFE, 8'h12);

        // R5 internal word push
        stk(1'b0, 1'b1, 16'hBEEF, 16'h0000);
        rd_chk("R5 pointer low", 8'hFF, 8'h3D);
        rd_chk("R5 high byte", 8'h3D, 8'hBE);
        rd_chk("R5 low byte", 8'h3E, 8'hEF);

        // R6 internal pops
        stk(1'b1, 1'b1, 16'h0000, 16'hBEEF);
        rd_chk("R6 pointer after word pop", 8'hFF, 8'h3F);
        stk(1'b1, 1'b0, 16'h0000, 16'h00A5);
        rd_chk("R6 pointer after byte pop", 8'hFF, 8'h40);

        // R10 no memory traffic for the internal stack
        chk("R10 dm requests", 32'(dm_log.size()), 32'd0);

        // R7 / R8 external stack
        wr(8'hF8, 8'h00);
        wr(8'hFE, 8'h00);
        wr(8'hFF, 8'h01);
        dm_log.delete();
        stk(1'b0, 1'b1, 16'h1234, 16'h0000);
        rd_chk("R7 pointer high borrow", 8'hFE, 8'hFF);
        rd_chk("R7 pointer low", 8'hFF, 8'hFF);
        chk("R7 memory high byte", 32'(dm_mem[16'hFFFF]), 32'h12);
        chk("R7 memory low byte", 32'(dm_mem[16'h0000]), 32'h34);
        chk("R8 request count", 32'(dm_log.size()), 32'd2);
        if (dm_log.size() == 2) begin
            chk("R8 first address", 32'(dm_log[0]), 32'hFFFF);
            chk("R8 second address", 32'(dm_log[1]), 32'h0000);
        end
        stk(1'b1, 1'b1, 16'h0000, 16'h1234);
        rd_chk("R7 pointer high after pop", 8'hFE, 8'h00);
        rd_chk("R7 pointer low after pop", 8'hFF, 8'h01);
        wr(8'hFE, 8'h01);
        wr(8'hFF, 8'h00);
        stk(1'b0, 1'b0, 16'h0077, 16'h0000);
        rd_chk("R7 byte push borrow high", 8'hFE, 8'h00);
        rd_chk("R7 byte push borrow low", 8'hFF, 8'hFF);
        chk("R7 memory byte", 32'(dm_mem[16'h00FF]), 32'h77);
        stk(1'b1, 1'b0, 16'h0000, 16'h0077);
        rd_chk("R7 byte pop carry high", 8'hFE, 8'h01);
        rd_chk("R7 byte pop carry low", 8'hFF, 8'h00);

        repeat (4) @(negedge clk);
        chk("R6 all pops seen", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule